// File: doc/BRIEF.md
# Idle Wake and Acknowledge Controller

This block sits beside a processor core and owns its idle low-power state. The core strobes an entry request. The block then latches two wake-block bits and the core's service context, and it holds an idle flag until a wake event arrives. A wake event is a non-maskable request, one of several maskable request lines that is not masked, or the synchronous reset.

When idle ends, the block makes a second decision in the same cycle: whether the waking event is accepted as an interrupt. The event can be acknowledged with a vector ID. If it is not, it is held in a sticky pending flag and the core continues with its next instruction. That decision depends on the context captured at entry: whether a non-maskable handler was running, the priority of any maskable handler in service, and the interrupt-enable state.

Top module: `idle_wake_ctrl`

## Requirements
- R1: `idle_enter` while not idle raises `idle_active` on the next cycle and captures the wake-block bits and context. `idle_enter` while already idle is ignored and changes no captured state.
- R2: If either wake-block bit (`wblk_maskable`, `wblk_nmi`) was 1 at entry, no interrupt request ends idle.
- R3: With both wake-block bits 0 at entry, `nmi_req` or any request line whose `irq_mask` bit is 0 ends idle, whatever its priority. Lines whose mask bit is 1 are ignored.
- R4: `clk_resume` is a single-cycle pulse in the same cycle that `idle_active` falls. `ack` and `resume_next` are valid only in that cycle, and exactly one of them is 1.
- R5: The winning request is the NMI if present (`ack_id` = 4). Otherwise it is the unmasked line with the numerically lowest 2-bit priority (line n uses `irq_prio[2n+1:2n]`), and ties go to the lowest line index. `ack_id` is the line index 0 to 3.
- R6: If the context at entry was a maskable handler, the winner is acknowledged only when it is the NMI or its priority value is strictly below `svc_prio`. Otherwise it is held pending and `resume_next` is 1.
- R7: If the context at entry was an NMI handler, every wake is held pending and is not acknowledged.
- R8: Outside any handler, an NMI wake is acknowledged whatever the state of `int_en`. A maskable wake is acknowledged if `int_en` was 1 at entry; otherwise it is held pending with `resume_next` set.
- R9: `pending` is set by an unacknowledged wake and records that request's ID. It clears only when a later wake acknowledges the same ID, or on reset.
- R10: A synchronous `rst` clears `idle_active`, `pending` and all decision outputs. This includes a reset that arrives during idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, also a wake source |
| idle_enter | input | 1 | Idle entry strobe |
| wblk_maskable | input | 1 | Blocks interrupt wake when 1 at entry |
| wblk_nmi | input | 1 | Blocks interrupt wake when 1 at entry |
| irq_req | input | 4 | Maskable request lines |
| irq_mask | input | 4 | Per-line mask, 1 = masked |
| irq_prio | input | 8 | 2-bit priority per line, 0 highest |
| nmi_req | input | 1 | Non-maskable request |
| int_en | input | 1 | Core interrupt-enable flag |
| in_nmi_svc | input | 1 | Core is in an NMI handler |
| in_irq_svc | input | 1 | Core is in a maskable handler |
| svc_prio | input | 2 | Priority of the maskable handler in service |
| idle_active | output | 1 | Idle state flag |
| clk_resume | output | 1 | One-cycle clock resume pulse |
| ack | output | 1 | Wake request acknowledged |
| ack_id | output | 3 | ID of the waking request, 4 = NMI |
| pending | output | 1 | Sticky unacknowledged-request flag |
| resume_next | output | 1 | Core continues at its next instruction |

## Verification
The assertions watch timing and consistency on every cycle. They check that the resume pulse lines up with the falling idle flag and lasts one cycle, that acknowledge and continue never appear together or outside a resume, and that a blocked entry is never woken by an interrupt. They also check that idle rises only after an entry strobe and that pending drops only on an acknowledge. Which request wins, and whether the context at entry leads to acknowledge or hold, can only be shown by the bench's scenarios. These include priority ties, NMI against maskable, handler-priority comparisons, and a pending ID that survives an unrelated acknowledge.

// File: rtl/idle_wake_pkg.sv
package idle_wake_pkg;
  // Context captured when idle is entered
  typedef struct packed {
    logic       blk;      // interrupt wake blocked
    logic       in_nmi;   // entered inside NMI handler
    logic       in_irq;   // entered inside maskable handler
    logic       ie;       // interrupt enable at entry
  } idle_ctx_t;

  function automatic logic prio_outranks(input int unsigned a, input int unsigned b);
    return a < b;
  endfunction
endpackage

// File: rtl/idle_wake_arbiter.sv
module idle_wake_arbiter #(
  parameter int NUM_IRQ = 4,
  parameter int PRIO_W  = 2,
  localparam int ID_W   = $clog2(NUM_IRQ + 1)
) (
  input  logic [NUM_IRQ-1:0]        req,
  input  logic [NUM_IRQ-1:0]        mask,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio,
  output logic                      any_valid,
  output logic [ID_W-1:0]           win_idx,
  output logic [PRIO_W-1:0]         win_prio
);
  logic [PRIO_W-1:0] p_arr [NUM_IRQ];
  logic [NUM_IRQ-1:0] en;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_unpack
    assign p_arr[g] = prio[g*PRIO_W +: PRIO_W];
    assign en[g]    = req[g] & ~mask[g];
  end

  always_comb begin
    any_valid = 1'b0;
    win_idx   = '0;
    win_prio  = '0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      // strict compare keeps the lower index on a tie
      if (en[i] && (!any_valid || (p_arr[i] < win_prio))) begin
        any_valid = 1'b1;
        win_idx   = ID_W'(i);
        win_prio  = p_arr[i];
      end
    end
  end
endmodule

// File: rtl/idle_wake_decider.sv
module idle_wake_decider
  import idle_wake_pkg::*;
#(
  parameter int PRIO_W = 2
) (
  input  idle_ctx_t         ctx,
  input  logic [PRIO_W-1:0] ctx_prio,
  input  logic              nmi,
  input  logic              any_irq,
  input  logic [PRIO_W-1:0] win_prio,
  output logic              wake,
  output logic              do_ack
);
  logic outranks;

  always_comb begin
    wake     = !ctx.blk && (nmi || any_irq);
    outranks = nmi || prio_outranks(int'(win_prio), int'(ctx_prio));
    if (ctx.in_nmi)      do_ack = 1'b0;
    else if (ctx.in_irq) do_ack = outranks;
    else                 do_ack = nmi || ctx.ie;
    do_ack = do_ack && wake;
  end
endmodule

// File: rtl/idle_wake_pending.sv
module idle_wake_pending #(
  parameter int ID_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold_fire,
  input  logic            ack_fire,
  input  logic [ID_W-1:0] evt_id,
  output logic            pending
);
  logic [ID_W-1:0] pend_id;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      pend_id <= '0;
    end else if (hold_fire) begin
      pending <= 1'b1;
      pend_id <= evt_id;
    end else if (ack_fire && pending && (evt_id == pend_id)) begin
      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/idle_wake_ctrl.sv
module idle_wake_ctrl
  import idle_wake_pkg::*;
#(
  parameter int NUM_IRQ = 4,
  parameter int PRIO_W  = 2,
  localparam int ID_W   = $clog2(NUM_IRQ + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      idle_enter,
  input  logic                      wblk_maskable,
  input  logic                      wblk_nmi,
  input  logic [NUM_IRQ-1:0]        irq_req,
  input  logic [NUM_IRQ-1:0]        irq_mask,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  input  logic                      nmi_req,
  input  logic                      int_en,
  input  logic                      in_nmi_svc,
  input  logic                      in_irq_svc,
  input  logic [PRIO_W-1:0]         svc_prio,
  output logic                      idle_active,
  output logic                      clk_resume,
  output logic                      ack,
  output logic [ID_W-1:0]           ack_id,
  output logic                      pending,
  output logic                      resume_next
);
  localparam logic [ID_W-1:0] NMI_ID = ID_W'(NUM_IRQ);

  idle_ctx_t         ctx_q;
  logic [PRIO_W-1:0] ctx_prio_q;
  logic              any_irq;
  logic [ID_W-1:0]   irq_idx;
  logic [PRIO_W-1:0] irq_win_prio;
  logic              wake, do_ack;
  logic [ID_W-1:0]   evt_id;
  logic              hold_fire, ack_fire;

  idle_wake_arbiter #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_arb (
    .req(irq_req), .mask(irq_mask), .prio(irq_prio),
    .any_valid(any_irq), .win_idx(irq_idx), .win_prio(irq_win_prio)
  );

  idle_wake_decider #(.PRIO_W(PRIO_W)) u_dec (
    .ctx(ctx_q), .ctx_prio(ctx_prio_q), .nmi(nmi_req), .any_irq(any_irq),
    .win_prio(irq_win_prio), .wake(wake), .do_ack(do_ack)
  );

  assign evt_id    = nmi_req ? NMI_ID : irq_idx;
  assign hold_fire = idle_active && wake && !do_ack;
  assign ack_fire  = idle_active && wake && do_ack;

  idle_wake_pending #(.ID_W(ID_W)) u_pend (
    .clk(clk), .rst(rst), .hold_fire(hold_fire), .ack_fire(ack_fire),
    .evt_id(evt_id), .pending(pending)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_active <= 1'b0;
      ctx_q       <= '0;
      ctx_prio_q  <= '0;
      clk_resume  <= 1'b0;
      ack         <= 1'b0;
      ack_id      <= '0;
      resume_next <= 1'b0;
    end else begin
      clk_resume  <= 1'b0;
      ack         <= 1'b0;
      resume_next <= 1'b0;
      if (!idle_active) begin
        if (idle_enter) begin
          idle_active   <= 1'b1;
          ctx_q.blk     <= wblk_maskable | wblk_nmi;
          ctx_q.in_nmi  <= in_nmi_svc;
          ctx_q.in_irq  <= in_irq_svc;
          ctx_q.ie      <= int_en;
          ctx_prio_q    <= svc_prio;
        end
      end else if (wake) begin
        idle_active <= 1'b0;
        clk_resume  <= 1'b1;
        ack         <= do_ack;
        ack_id      <= evt_id;
        resume_next <= !do_ack;
      end
    end
  end
endmodule

// File: rtl/idle_wake_checker.sv
module idle_wake_checker #(
  parameter int ID_W = 3,
  parameter int NUM_IRQ = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            idle_enter,
  input logic            wblk_maskable,
  input logic            wblk_nmi,
  input logic            idle_active,
  input logic            clk_resume,
  input logic            ack,
  input logic [ID_W-1:0] ack_id,
  input logic            pending,
  input logic            resume_next
);
  logic blk_q;

  always_ff @(posedge clk) begin
    if (rst) blk_q <= 1'b0;
    else if (idle_enter && !idle_active) blk_q <= wblk_maskable | wblk_nmi;
  end

  assert_idle_rise_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(idle_active) |-> $past(idle_enter));

  assert_block_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (idle_active && blk_q) |=> idle_active);

  assert_resume_on_fall_R4: assert property (@(posedge clk) disable iff (rst)
    clk_resume |-> ($past(idle_active) && !idle_active));

  assert_resume_single_R4: assert property (@(posedge clk) disable iff (rst)
    clk_resume |=> !clk_resume);

  assert_decision_in_resume_R4: assert property (@(posedge clk) disable iff (rst)
    (ack || resume_next) |-> clk_resume);

  assert_ack_or_hold_R4: assert property (@(posedge clk) disable iff (rst)
    clk_resume |-> (ack != resume_next));

  assert_id_range_R5: assert property (@(posedge clk) disable iff (rst)
    ack |-> (ack_id <= ID_W'(NUM_IRQ)));

  assert_pending_clear_R9: assert property (@(posedge clk) disable iff (rst)
    ($fell(pending) && !$past(rst)) |-> ack);
endmodule

bind idle_wake_ctrl idle_wake_checker #(.ID_W(ID_W), .NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst(rst), .idle_enter(idle_enter), .wblk_maskable(wblk_maskable),
  .wblk_nmi(wblk_nmi), .idle_active(idle_active), .clk_resume(clk_resume),
  .ack(ack), .ack_id(ack_id), .pending(pending), .resume_next(resume_next)
);

// File: tb/idle_wake_ctrl_bench.sv
module idle_wake_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic idle_enter = 1'b0, wblk_maskable = 1'b0, wblk_nmi = 1'b0;
  logic [3:0] irq_req = '0, irq_mask = '0;
  logic [7:0] irq_prio = '0;
  logic nmi_req = 1'b0, int_en = 1'b0, in_nmi_svc = 1'b0, in_irq_svc = 1'b0;
  logic [1:0] svc_prio = '0;
  logic idle_active, clk_resume, ack, pending, resume_next;
  logic [2:0] ack_id;

  int n_vec = 0, n_bad = 0;
  // bench copy of captured context and pending record
  bit c_blk, c_nmi, c_irq, c_ie;
  bit [1:0] c_prio;
  bit m_pend;
  bit [2:0] m_pid;

  always #2 clk = ~clk;

  idle_wake_ctrl u_idle_wake_ctrl (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // returns {wake, ack, id[2:0]}
  function automatic bit [4:0] model(bit nmi, bit [3:0] r, bit [3:0] m, bit [7:0] p);
    bit [3:0] en = r & ~m;
    bit wk, ak, found, hi;
    bit [2:0] id;
    bit [1:0] wp;
    wk = !c_blk && (nmi || (en != 0));
    found = 0; id = 0; wp = 0;
    if (nmi) id = 3'd4;
    else
      for (int pv = 0; pv < 4; pv++)
        for (int ln = 0; ln < 4; ln++)
          if (!found && en[ln] && (p[2*ln +: 2] == 2'(pv))) begin
            found = 1; id = 3'(ln); wp = 2'(pv);
          end
    hi = nmi || (wp < c_prio);
    if (c_nmi) ak = 0;
    else if (c_irq) ak = hi;
    else ak = nmi || c_ie;
    return {wk, ak && wk, id};
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    m_pend = 0; m_pid = 0;
    chk("R10 idle after reset", int'(idle_active), 0);
    chk("R10 pending after reset", int'(pending), 0);
    chk("R10 resume after reset", int'(clk_resume), 0);
  endtask

  task automatic enter(bit wm, bit wn, bit inn, bit inq, bit [1:0] cp, bit ie);
    wblk_maskable = wm; wblk_nmi = wn; in_nmi_svc = inn; in_irq_svc = inq;
    svc_prio = cp; int_en = ie; idle_enter = 1'b1;
    c_blk = wm | wn; c_nmi = inn; c_irq = inq; c_prio = cp; c_ie = ie;
    @(negedge clk);
    idle_enter = 1'b0;
    chk("R1 idle entered", int'(idle_active), 1);
  endtask

  task automatic fire(bit nmi, bit [3:0] r, bit [3:0] m, bit [7:0] p);
    bit [4:0] e = model(nmi, r, m, p);
    nmi_req = nmi; irq_req = r; irq_mask = m; irq_prio = p;
    @(negedge clk);
    nmi_req = 0; irq_req = 0;
    if (e[4]) begin
      chk("R3 idle ends", int'(idle_active), 0);
      chk("R4 resume pulse", int'(clk_resume), 1);
      chk("R6 R7 R8 ack", int'(ack), int'(e[3]));
      chk("R8 resume_next", int'(resume_next), int'(!e[3]));
      chk("R5 event id", int'(ack_id), int'(e[2:0]));
      if (!e[3]) begin m_pend = 1; m_pid = e[2:0]; end
      else if (m_pend && m_pid == e[2:0]) m_pend = 0;
      chk("R9 pending", int'(pending), int'(m_pend));
      @(negedge clk);
      chk("R4 pulse ends", int'(clk_resume | ack | resume_next), 0);
    end else begin
      chk("R2 R3 stays idle", int'(idle_active), 1);
      chk("R2 R3 no resume", int'(clk_resume), 0);
      do_reset();
    end
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    @(negedge clk);
    do_reset();
    // R1: second entry strobe while idle must not recapture a block bit
    enter(0, 0, 0, 0, 2'd0, 1);
    wblk_maskable = 1; wblk_nmi = 1; idle_enter = 1;
    @(negedge clk);
    idle_enter = 0; c_blk = 0;
    chk("R1 re-entry ignored", int'(idle_active), 1);
    fire(0, 4'b0001, 4'b0000, 8'h00);
    // R5 tie: lines 1 and 3 equal priority -> line 1
    enter(0, 0, 0, 0, 2'd0, 1);
    fire(0, 4'b1010, 4'b0000, 8'b10_00_10_00);
    // R5 NMI beats a top-priority line
    enter(0, 0, 0, 0, 2'd0, 1);
    fire(1, 4'b1111, 4'b0000, 8'h00);
    // R6 equal priority in maskable handler -> hold
    enter(0, 0, 0, 1, 2'd1, 1);
    fire(0, 4'b0100, 4'b0000, 8'b00_01_00_00);
    do_reset();
    // R7 NMI inside NMI handler -> hold
    enter(0, 0, 1, 0, 2'd0, 1);
    fire(1, 4'b0000, 4'b0000, 8'h00);
    do_reset();
    // R8 NMI with interrupts disabled -> ack
    enter(0, 0, 0, 0, 2'd0, 0);
    fire(1, 4'b0000, 4'b0000, 8'h00);
    // R9 pending id 2 survives ack of id 0, cleared by ack of id 2
    enter(0, 0, 0, 0, 2'd0, 0);
    fire(0, 4'b0100, 4'b0000, 8'h00);
    enter(0, 0, 0, 0, 2'd0, 1);
    fire(0, 4'b0001, 4'b0000, 8'h00);
    enter(0, 0, 0, 0, 2'd0, 1);
    fire(0, 4'b0100, 4'b0000, 8'h00);
    // R2 blocked entry, then R3 masked line ignored, both leave via reset
    enter(1, 0, 0, 0, 2'd0, 1);
    fire(1, 4'b1111, 4'b0000, 8'h00);
    enter(0, 0, 0, 0, 2'd0, 1);
    fire(0, 4'b0010, 4'b0010, 8'h00);
    // R10 reset during idle
    enter(0, 0, 0, 0, 2'd0, 1);
    do_reset();
    for (int k = 0; k < 400; k++) begin
      bit [31:0] rv = $urandom;
      enter(rv[0] & rv[1] & rv[2], rv[3] & rv[4] & rv[5], rv[6] & rv[7],
            rv[8], rv[10:9], rv[11]);
      fire(rv[12] & rv[13], rv[17:14], rv[21:18] & rv[25:22], $urandom);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule